// File: doc/BRIEF.md
# Indexed Vector Gather/Scatter Sequencer

This block carries out one indexed vector memory operation at a time for a vector of `LANES` elements. In gather mode, each enabled lane reads the memory word at the base address plus that lane's index and places it in the result vector. In scatter mode, each enabled lane's data element is written to its indexed word. Indices count 32-bit words. The word address is the base word address (base bits above bit 1) plus the index, wrapped to the address width. A per-lane enable mask switches lanes off.

The memory side is a single port that is one line wide. A line is 64 bytes, which is 16 words. Each access moves one whole line, with a per-word write strobe. The sequencer takes the lowest-numbered pending lane as the leader. It then gathers every pending lane whose word address has the same line number (the word-address bits above the 4-bit word offset) into one access, and retires that group. So an operation costs one access per distinct line touched.

In gather mode, the data vector is the merge source. Disabled lanes return their data-vector element unchanged. A single-cycle `done` marks the end of the operation.

Top module: `vgs_sequencer`

## Requirements
- R1: In gather mode (`mode`=0), result lane i equals the memory word at word address (base[9:2] + idx[i]) mod 256 when `done` is high.
- R2: In scatter mode (`mode`=1), data lane i is written to word address (base[9:2] + idx[i]) mod 256. Word w of a line access sits at `mem_wdata[32*w +: 32]`, and its enable is `mem_wstrb[w]`.
- R3: A lane whose mask bit is 0 causes no memory access and no write. In gather mode, its result lane equals the corresponding lane of `data_vec`.
- R4: When all enabled lanes share one line number (word-address bits [7:4]), the operation issues exactly one access.
- R5: When enabled lanes touch k distinct lines, exactly k accesses are issued, one after another. Each access is one cycle of `mem_req`. Gather reads return `mem_rdata` with `mem_rvalid` one or more cycles after the request.
- R6: In scatter mode, when several lanes target the same word, the highest-numbered lane's value is the one left in memory.
- R7: `done` is high for exactly one cycle, in the cycle after the last access completes. With an all-zero mask, `done` still pulses and no access is made.
- R8: A `start` pulse that arrives while an operation is in progress is ignored. It causes no extra access, no extra `done` and no change to the result or to memory.
- R9: After reset, `done`, `mem_req` and `result_vec` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins an operation when idle |
| mode | input | 1 | 0 = gather, 1 = scatter |
| base | input | 10 | Byte base address (bits 1:0 ignored) |
| idx_vec | input | 32 | Per-lane word indices, 8 bits per lane |
| data_vec | input | 128 | Scatter data, or gather merge source |
| lane_mask | input | 4 | Per-lane enable |
| mem_req | output | 1 | One line access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_line | output | 4 | Line number |
| mem_wstrb | output | 16 | Per-word write enable |
| mem_wdata | output | 512 | Line write data |
| mem_rvalid | input | 1 | Read line data is valid |
| mem_rdata | input | 512 | Read line data |
| result_vec | output | 128 | Gather result |
| done | output | 1 | One-cycle completion pulse |

## Verification
An operation starts on the clock edge after `start`. Every scatter line access then takes one cycle. A gather line access takes a request cycle and at least two further cycles, because the bench memory returns data on the edge after it sees the request. `done` comes one cycle after the last access. The bench therefore does not wait a fixed number of cycles. It waits for `done`, and then idles three more cycles so that any late extra pulse or access is still seen. Accesses and `done` pulses are counted at the clock edge, while results and memory are compared at the falling edge after the operation has settled.

// File: rtl/vgs_pkg.sv
package vgs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_FIN   = 2'd3
  } vgs_state_t;
endpackage

// File: rtl/vgs_lane_addr.sv
module vgs_lane_addr #(
  parameter int LANES = 4,
  parameter int WA    = 8,
  parameter int OFFW  = 4
) (
  input  logic [WA-1:0]                  base_w,
  input  logic [LANES-1:0][WA-1:0]       idx,
  output logic [LANES-1:0][WA-OFFW-1:0]  line,
  output logic [LANES-1:0][OFFW-1:0]     off
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [WA-1:0] wa;
    assign wa      = base_w + idx[g];
    assign line[g] = wa[WA-1:OFFW];
    assign off[g]  = wa[OFFW-1:0];
  end
endmodule

// File: rtl/vgs_line_group.sv
module vgs_line_group #(
  parameter int LANES = 4,
  parameter int EW    = 32,
  parameter int LW    = 4,
  parameter int OFFW  = 4,
  localparam int LINE_WORDS = 1 << OFFW
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic [LANES-1:0]                   pend,
  input  logic [LANES-1:0][LW-1:0]           line,
  input  logic [LANES-1:0][OFFW-1:0]         off,
  input  logic [LANES-1:0][EW-1:0]           data,
  output logic [LW-1:0]                      lead_line,
  output logic [LANES-1:0]                   grp,
  output logic [LINE_WORDS-1:0]              wstrb,
  output logic [LINE_WORDS-1:0][EW-1:0]      wdata
);
  logic found;

  always_comb begin
    found     = 1'b0;
    lead_line = '0;
    for (int i = 0; i < LANES; i++) begin
      if (pend[i] && !found) begin
        found     = 1'b1;
        lead_line = line[i];
      end
    end
    grp   = '0;
    wstrb = '0;
    wdata = '0;
    // ascending walk: a later lane overwrites an earlier one on the same word
    for (int i = 0; i < LANES; i++) begin
      grp[i] = pend[i] && (line[i] == lead_line);
      if (grp[i]) begin
        wstrb[off[i]] = 1'b1;
        wdata[off[i]] = data[i];
      end
    end
  end

  AST_GROUP_HAS_LEADER: assert property (@(posedge clk) disable iff (rst)
    (|pend) |-> (|grp)); // R4

endmodule

// File: rtl/vgs_sequencer.sv
module vgs_sequencer #(
  parameter int LANES      = 4,
  parameter int EW         = 32,
  parameter int AW         = 10,
  parameter int LINE_BYTES = 64,
  localparam int WA         = AW - 2,
  localparam int LINE_WORDS = LINE_BYTES / 4,
  localparam int OFFW       = $clog2(LINE_WORDS),
  localparam int LW         = WA - OFFW
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic                      mode,
  input  logic [AW-1:0]             base,
  input  logic [LANES*WA-1:0]       idx_vec,
  input  logic [LANES*EW-1:0]       data_vec,
  input  logic [LANES-1:0]          lane_mask,
  output logic                      mem_req,
  output logic                      mem_we,
  output logic [LW-1:0]             mem_line,
  output logic [LINE_WORDS-1:0]     mem_wstrb,
  output logic [LINE_WORDS*EW-1:0]  mem_wdata,
  input  logic                      mem_rvalid,
  input  logic [LINE_WORDS*EW-1:0]  mem_rdata,
  output logic [LANES*EW-1:0]       result_vec,
  output logic                      done
);
  import vgs_pkg::*;

  vgs_state_t                 state;
  logic                       mode_q;
  logic [WA-1:0]              base_q;
  logic [LANES-1:0][WA-1:0]   idx_q;
  logic [LANES-1:0][EW-1:0]   data_q;
  logic [LANES-1:0][EW-1:0]   res_q;
  logic [LANES-1:0]           pend;

  logic [LANES-1:0][LW-1:0]          lane_line;
  logic [LANES-1:0][OFFW-1:0]        lane_off;
  logic [LW-1:0]                     lead_line;
  logic [LANES-1:0]                  grp;
  logic [LINE_WORDS-1:0]             grp_wstrb;
  logic [LINE_WORDS-1:0][EW-1:0]     grp_wdata;
  logic [LINE_WORDS-1:0][EW-1:0]     rdata_a;
  logic [LANES-1:0]                  pend_next;

  assign rdata_a    = mem_rdata;
  assign result_vec = res_q;
  assign pend_next  = pend & ~grp;

  vgs_lane_addr #(.LANES(LANES), .WA(WA), .OFFW(OFFW)) u_addr (
    .base_w (base_q),
    .idx    (idx_q),
    .line   (lane_line),
    .off    (lane_off)
  );

  vgs_line_group #(.LANES(LANES), .EW(EW), .LW(LW), .OFFW(OFFW)) u_group (
    .clk       (clk),
    .rst       (rst),
    .pend      (pend),
    .line      (lane_line),
    .off       (lane_off),
    .data      (data_q),
    .lead_line (lead_line),
    .grp       (grp),
    .wstrb     (grp_wstrb),
    .wdata     (grp_wdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      mode_q    <= 1'b0;
      base_q    <= '0;
      idx_q     <= '0;
      data_q    <= '0;
      res_q     <= '0;
      pend      <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_line  <= '0;
      mem_wstrb <= '0;
      mem_wdata <= '0;
      done      <= 1'b0;
    end else begin
      mem_req <= 1'b0;
      done    <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            mode_q <= mode;
            base_q <= base[AW-1:2];
            idx_q  <= idx_vec;
            data_q <= data_vec;
            pend   <= lane_mask;
            if (!mode) res_q <= data_vec;
            state  <= (|lane_mask) ? ST_ISSUE : ST_FIN;
          end
        end
        ST_ISSUE: begin
          mem_req   <= 1'b1;
          mem_we    <= mode_q;
          mem_line  <= lead_line;
          mem_wstrb <= mode_q ? grp_wstrb : '0;
          mem_wdata <= grp_wdata;
          if (mode_q) begin
            pend  <= pend_next;
            state <= (pend_next == '0) ? ST_FIN : ST_ISSUE;
          end else begin
            state <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (mem_rvalid) begin
            for (int i = 0; i < LANES; i++)
              if (grp[i]) res_q[i] <= rdata_a[lane_off[i]];
            pend  <= pend_next;
            state <= (pend_next == '0) ? ST_FIN : ST_ISSUE;
          end
        end
        default: begin
          done  <= 1'b1;
          state <= ST_IDLE;
        end
      endcase
    end
  end

  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !mem_req); // R3
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R7
  AST_WRITE_HAS_STRB: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> (mem_wstrb != '0)); // R2
  AST_GATHER_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mode_q) |-> (!mem_we && mem_wstrb == '0)); // R1
  AST_PEND_SHRINKS: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && mem_rvalid) |=> ($countones(pend) < $countones($past(pend)))); // R5
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE && start) |=> ($stable(mode_q) && $stable(base_q) && $stable(idx_q))); // R8

endmodule

// File: tb/vgs_sequencer_test.sv
module vgs_sequencer_test;
  localparam int LANES = 4;
  localparam int EW    = 32;
  localparam int AW    = 10;
  localparam int WA    = 8;
  localparam int LWD   = 16;
  localparam int NW    = 256;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic mode = 1'b0;
  logic [AW-1:0] base = '0;
  logic [LANES*WA-1:0] idx_vec = '0;
  logic [LANES*EW-1:0] data_vec = '0;
  logic [LANES-1:0] lane_mask = '0;
  logic mem_req, mem_we, done;
  logic [3:0] mem_line;
  logic [LWD-1:0] mem_wstrb;
  logic [LWD*EW-1:0] mem_wdata;
  logic mem_rvalid = 1'b0;
  logic [LWD*EW-1:0] mem_rdata = '0;
  logic [LANES*EW-1:0] result_vec;

  logic [EW-1:0] mem [NW];
  logic [EW-1:0] shadow [NW];
  int acc_cnt = 0;
  int done_cnt = 0;
  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  vgs_sequencer uut (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .base(base),
    .idx_vec(idx_vec), .data_vec(data_vec), .lane_mask(lane_mask),
    .mem_req(mem_req), .mem_we(mem_we), .mem_line(mem_line),
    .mem_wstrb(mem_wstrb), .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .result_vec(result_vec), .done(done)
  );

  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (done) done_cnt <= done_cnt + 1;
    if (mem_req) begin
      acc_cnt <= acc_cnt + 1;
      if (mem_we) begin
        for (int w = 0; w < LWD; w++)
          if (mem_wstrb[w]) mem[{mem_line, 4'(w)}] <= mem_wdata[w*EW +: EW];
      end else begin
        mem_rvalid <= 1'b1;
        for (int w = 0; w < LWD; w++)
          mem_rdata[w*EW +: EW] <= mem[{mem_line, 4'(w)}];
      end
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000 && !finished) begin
      fails = fails + 1;
      checks = checks + 1;
      $display("FAIL R7 watchdog expired: actual no finish, expected finish");
      summary();
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] waddr(input logic [AW-1:0] b, input logic [LANES*WA-1:0] iv, input int i);
    return 8'(b[AW-1:2] + iv[i*WA +: WA]);
  endfunction

  task automatic run_op(input bit md, input logic [AW-1:0] b, input logic [LANES*WA-1:0] iv,
                        input logic [LANES*EW-1:0] dv, input logic [LANES-1:0] mk, input bit poke);
    logic [LANES*EW-1:0] exp_res;
    logic [15:0] lines_seen;
    int exp_acc;
    int waited;
    for (int w = 0; w < NW; w++) shadow[w] = mem[w];
    exp_res = md ? result_vec : dv;
    lines_seen = '0;
    for (int i = 0; i < LANES; i++) begin
      if (mk[i]) begin
        lines_seen[waddr(b, iv, i) >> 4] = 1'b1;
        if (md) shadow[waddr(b, iv, i)] = dv[i*EW +: EW];       // R6 ascending, last wins
        else    exp_res[i*EW +: EW] = mem[waddr(b, iv, i)];
      end
    end
    exp_acc = $countones(lines_seen);
    @(negedge clk);
    acc_cnt = 0; done_cnt = 0;
    mode = md; base = b; idx_vec = iv; data_vec = dv; lane_mask = mk; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      @(negedge clk);
      mode = ~md; base = b + 10'd64; lane_mask = 4'hF; data_vec = ~dv; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    waited = 0;
    while (done_cnt == 0 && waited < 100) begin
      @(negedge clk);
      waited++;
    end
    repeat (3) @(negedge clk);
    check(done_cnt == 1, poke ? "R8 done count" : "R7 done count", 128'(done_cnt), 128'd1);
    check(acc_cnt == exp_acc, poke ? "R8 access count" : (exp_acc <= 1 ? "R4 access count" : "R5 access count"),
          128'(acc_cnt), 128'(exp_acc));
    if (md) begin
      int bad = 0;
      for (int w = 0; w < NW; w++) if (mem[w] !== shadow[w]) bad++;
      check(bad == 0, "R2/R3/R6 memory image", 128'(bad), 128'd0);
    end else begin
      check(result_vec === exp_res, "R1/R3 gather result", result_vec, exp_res);
    end
  endtask

  initial begin
    for (int w = 0; w < NW; w++) mem[w] = 32'hC0DE_0000 ^ (32'(w) * 32'h0101_0107);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(done == 1'b0 && mem_req == 1'b0, "R9 reset outputs", {126'd0, done, mem_req}, 128'd0);
    check(result_vec == '0, "R9 reset result", result_vec, 128'd0);
    for (int p = 0; p < 6; p++) begin
      for (int mk = 0; mk < 16; mk++) begin
        for (int md = 0; md < 2; md++) begin
          logic [LANES*WA-1:0] iv;
          logic [LANES*EW-1:0] dv;
          logic [AW-1:0] b;
          b = 10'(p * 52 + mk * 12);
          for (int i = 0; i < LANES; i++) begin
            case (p)
              0: iv[i*WA +: WA] = 8'(i);                    // one line (R4)
              1: iv[i*WA +: WA] = 8'(i * 16);               // four lines (R5)
              2: iv[i*WA +: WA] = 8'd5;                     // same word (R6)
              3: iv[i*WA +: WA] = 8'((i / 2) * 33 + i);     // pairs share lines
              4: iv[i*WA +: WA] = 8'(250 + i * 3);          // wraps around address space
              default: iv[i*WA +: WA] = 8'(mk * 37 + i * 71);
            endcase
            dv[i*EW +: EW] = 32'h5A00_0000 + 32'(p * 1000 + mk * 10 + i + md * 7);
          end
          run_op(md[0], b, iv, dv, 4'(mk), 1'b0);
        end
      end
    end
    // R8: start during a busy gather and a busy scatter
    run_op(1'b0, 10'd16, {8'd200, 8'd100, 8'd50, 8'd0}, {32'h1, 32'h2, 32'h3, 32'h4}, 4'hF, 1'b1);
    run_op(1'b1, 10'd16, {8'd200, 8'd100, 8'd50, 8'd0}, {32'h11, 32'h22, 32'h33, 32'h44}, 4'hF, 1'b1);
    finished = 1'b1;
    summary();
    $finish;
  end
endmodule